// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM with Two-Stage Deselect

A behavioural synchronous static RAM. It has a parameterised number of words and, by default, four 8-bit byte lanes. The chip enables, address, write controls and write data are captured on the rising clock edge. Each accepted cycle becomes one of three commands: read, write or idle. Idle covers deselect, sleep and no selection. Writes can update every lane at once through the global write input, or only a chosen set of lanes through the byte-write enable and the lane selects. A mode input chooses whether read data reaches the outputs one cycle after the read command (flow-through) or two cycles after it (pipelined, with an extra output register).

Idle commands travel through the same stages as reads. In pipelined mode, the data of a read that is followed by a deselect therefore stays driven for a whole further cycle. The drivers turn off only after the second edge. The output enable and the sleep input gate the drivers combinationally, with no clock needed. While asleep, the RAM accepts no command, but it keeps its contents. The tri-state data bus is modelled as a data vector together with a driver-active flag. The data vector reads zero whenever the flag is low.

Top module: `sync_sram_dcd`

## Requirements
- R1: While reset is asserted, and after it is released until the first read is accepted, `dq_drive` is 0 and `dq` is 0.
- R2: A write cycle with `glob_wr` high updates every lane of the addressed word, whatever the values of `byte_wr` and `lane_sel`.
- R3: A write cycle with `glob_wr` low and `byte_wr` high updates exactly the lanes whose `lane_sel` bit is 1. Lane i is bits [8i+7:8i], and the other lanes keep their contents. `lane_sel` = 0 gives a write cycle that changes nothing.
- R4: With `pipe_mode` = 0, the data of a read accepted at edge k is driven from edge k until edge k+1.
- R5: With `pipe_mode` = 1, the data of a read accepted at edge k is driven from edge k+1 until edge k+2.
- R6: With `pipe_mode` = 1, an idle command accepted at edge k leaves the drivers as edge k-1 set them until edge k+1, and turns them off after edge k+1.
- R7: `out_en` = 0 turns the drivers off at once, without a clock edge. Setting it back to 1 restores the pending read data.
- R8: `doze` = 1 turns the drivers off at once. Any cycle sampled with `doze` high is idle, so a write sampled then leaves the memory unchanged.
- R9: Memory contents survive a sleep period, and commands are accepted again at the first edge after `doze` falls.
- R10: A read of the address that was written at the previous edge returns the newly written data.
- R11: The drivers are off in the cycle after an edge that accepted a write. They are also off when the pipeline stage selected by the mode holds no read.
- R12: A cycle is accepted only when `cs_a` is 1 and `cs_b_n` is 0. Otherwise it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output pipeline |
| cs_a | input | 1 | Chip enable, active high |
| cs_b_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| glob_wr | input | 1 | Write all lanes |
| byte_wr | input | 1 | Write the lanes chosen by lane_sel |
| lane_sel | input | LANES | Lane selects for byte writes |
| pipe_mode | input | 1 | 0 flow-through, 1 pipelined |
| out_en | input | 1 | Asynchronous output enable, active high |
| doze | input | 1 | Asynchronous sleep, active high |
| dq | output | LANES*LANE_W | Read data, zero while not driven |
| dq_drive | output | 1 | Output drivers active |

## Verification
The hardest state to reach from the ports is the pipelined hand-over. A read, then a deselect, must be followed straight away by a write or a change of output enable, so that the second stage still holds read data while the first stage holds something else. Fixed sequences cover the read–deselect and write–read orders. Long random runs in both modes then draw the command types with biased weights, so that these back-to-back orders occur often. A reference model in the bench tracks the two stages and predicts drivers and data for every cycle.

// File: rtl/sram_dcd_pkg.sv
package sram_dcd_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } sram_cmd_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
   import sram_dcd_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             cs_a,
   input  logic             cs_b_n,
   input  logic             doze,
   input  logic             glob_wr,
   input  logic             byte_wr,
   input  logic [LANES-1:0] lane_sel,
   output sram_cmd_e        cmd,
   output logic [LANES-1:0] lane_we
);
   logic selected;
   assign selected = cs_a && !cs_b_n && !doze;

   always_comb begin
      cmd     = CMD_IDLE;
      lane_we = '0;
      if (selected) begin
         if (glob_wr) begin
            cmd     = CMD_WRITE;
            lane_we = '1;
         end else if (byte_wr) begin
            cmd     = CMD_WRITE;
            lane_we = lane_sel;
         end else begin
            cmd = CMD_READ;
         end
      end
   end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
   parameter  int ADDR_W = 6,
   parameter  int LANES  = 4,
   parameter  int LANE_W = 8,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  lane_we,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
         if (rd_en)      lane_q      <= cells[addr];
      end

      assign rdata[g*LANE_W +: LANE_W] = lane_q;
   end
endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe
   import sram_dcd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sram_cmd_e         cmd,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              pipe_mode,
   input  logic              out_en,
   input  logic              doze,
   output logic [DATA_W-1:0] dq,
   output logic              dq_drive
);
   logic              s1_drv, s1_wr, s2_drv;
   logic [DATA_W-1:0] s2_dat;
   logic              sel_drv;
   logic [DATA_W-1:0] sel_dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_drv <= 1'b0;
         s1_wr  <= 1'b0;
         s2_drv <= 1'b0;
         s2_dat <= '0;
      end else begin
         s1_drv <= (cmd == CMD_READ);
         s1_wr  <= (cmd == CMD_WRITE);
         s2_drv <= s1_drv;
         s2_dat <= rd_data;
      end
   end

   assign sel_drv  = pipe_mode ? s2_drv : s1_drv;
   assign sel_dat  = pipe_mode ? s2_dat : rd_data;
   assign dq_drive = sel_drv && !s1_wr && out_en && !doze;
   assign dq       = dq_drive ? sel_dat : '0;

   a_r7_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> !dq_drive);
   a_r8_doze_gates: assert property (@(posedge clk) disable iff (!rst_n)
      doze |-> !dq_drive);
   a_r4_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_READ && !pipe_mode) |=> (dq_drive || pipe_mode || !out_en || doze));
   a_r6_dcd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_READ && pipe_mode) ##1 (cmd != CMD_WRITE)
      |=> (dq_drive || !pipe_mode || !out_en || doze));
   a_r6_dcd_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_READ) |-> ##2 (!dq_drive || !pipe_mode));
   a_r11_idle_flow: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_READ) |=> (!dq_drive || pipe_mode));
endmodule

// File: rtl/sync_sram_dcd.sv
module sync_sram_dcd
   import sram_dcd_pkg::*;
#(
   parameter  int ADDR_W = 6,
   parameter  int LANES  = 4,
   parameter  int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_a,
   input  logic              cs_b_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              glob_wr,
   input  logic              byte_wr,
   input  logic [LANES-1:0]  lane_sel,
   input  logic              pipe_mode,
   input  logic              out_en,
   input  logic              doze,
   output logic [DATA_W-1:0] dq,
   output logic              dq_drive
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("sync_sram_dcd: ADDR_W must lie in 1..12");
   end
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("sync_sram_dcd: LANES must lie in 1..16");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("sync_sram_dcd: LANE_W must be positive");
   end

   sram_cmd_e         cmd;
   logic [LANES-1:0]  lane_we;
   logic [DATA_W-1:0] arr_q;

   sram_cmd_decode #(.LANES(LANES)) i_decode (
      .cs_a     (cs_a),
      .cs_b_n   (cs_b_n),
      .doze     (doze),
      .glob_wr  (glob_wr),
      .byte_wr  (byte_wr),
      .lane_sel (lane_sel),
      .cmd      (cmd),
      .lane_we  (lane_we)
   );

   sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
      .clk     (clk),
      .lane_we (lane_we),
      .rd_en   (cmd == CMD_READ),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (arr_q)
   );

   sram_out_pipe #(.DATA_W(DATA_W)) i_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .rd_data   (arr_q),
      .pipe_mode (pipe_mode),
      .out_en    (out_en),
      .doze      (doze),
      .dq        (dq),
      .dq_drive  (dq_drive)
   );

   a_r11_write_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WRITE) |=> !dq_drive);
   a_r8_doze_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      doze |-> (lane_we == '0));
   a_r3_lane_subset: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_wr |-> ((lane_we & ~lane_sel) == '0));
   a_r12_unselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_a || cs_b_n) |-> (lane_we == '0));
endmodule

// File: tb/test_sync_sram_dcd.sv
module test_sync_sram_dcd;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 8;
   localparam int DW = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_a = 1'b0, cs_b_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          glob_wr = 1'b0, byte_wr = 1'b0;
   logic [NL-1:0] lane_sel = '0;
   logic          pipe_mode = 1'b0, out_en = 1'b1, doze = 1'b0;
   logic [DW-1:0] dq;
   logic          dq_drive;

   always #2 clk = ~clk;

   sync_sram_dcd #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_sync_sram_dcd (
      .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b_n(cs_b_n), .addr(addr),
      .wdata(wdata), .glob_wr(glob_wr), .byte_wr(byte_wr), .lane_sel(lane_sel),
      .pipe_mode(pipe_mode), .out_en(out_en), .doze(doze), .dq(dq), .dq_drive(dq_drive)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [DW-1:0] ref_mem [DEPTH];
   logic          m1_drv = 0, m1_wr = 0, m2_drv = 0;
   logic [DW-1:0] m1_dat = '0, m2_dat = '0;

   task automatic chk(string tag, logic [DW:0] act, logic [DW:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW:0] exp_out();
      logic d;
      d = (pipe_mode ? m2_drv : m1_drv) && !m1_wr && out_en && !doze;
      return {d, d ? (pipe_mode ? m2_dat : m1_dat) : {DW{1'b0}}};
   endfunction

   function automatic logic [DW-1:0] pat(int a);
      return 32'hA5000000 ^ (a * 32'h01030507);
   endfunction

   task automatic model_edge();
      logic acc, wr, rd;
      acc = cs_a && !cs_b_n && !doze;
      wr  = acc && (glob_wr || byte_wr);
      rd  = acc && !wr;
      m2_drv = m1_drv;
      m2_dat = m1_dat;
      m1_drv = rd;
      m1_wr  = wr;
      if (rd) m1_dat = ref_mem[addr];
      if (wr)
         for (int l = 0; l < NL; l++)
            if (glob_wr || lane_sel[l]) ref_mem[addr][l*LW +: LW] = wdata[l*LW +: LW];
   endtask

   // one clock: apply inputs at negedge, model the edge, check at next negedge
   task automatic cyc(logic ca, logic cbn, logic [AW-1:0] a, logic [DW-1:0] wd,
                      logic gw, logic bw, logic [NL-1:0] ls);
      logic [DW:0] e;
      cs_a = ca; cs_b_n = cbn; addr = a; wdata = wd;
      glob_wr = gw; byte_wr = bw; lane_sel = ls;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      e = exp_out();
      chk(!e[DW] ? "R11" : (pipe_mode ? "R5" : "R4"), {dq_drive, dq}, e);
   endtask

   task automatic rd(logic [AW-1:0] a);  cyc(1, 0, a, '0, 0, 0, '0); endtask
   task automatic idle();                cyc(0, 1, '0, '0, 0, 0, '0); endtask

   initial begin
      logic [DW-1:0] v;
      @(negedge clk);
      chk("R1 reset drive", {dq_drive, dq}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      chk("R1 after reset", {dq_drive, dq}, '0);

      // fill every word with glob_wr and lane selects cleared
      for (int i = 0; i < DEPTH; i++) cyc(1, 0, AW'(i), pat(i), 1, 0, '0);
      rd(AW'(5));
      chk("R2 global write all lanes", {dq_drive, dq}, {1'b1, pat(5)});

      // R3 byte write on lanes 0 and 2
      cyc(1, 0, AW'(5), 32'h11223344, 0, 1, 4'b0101);
      rd(AW'(5));
      v = pat(5);
      chk("R3 byte lanes", {dq_drive, dq}, {1'b1, v[31:24], 8'h22, v[15:8], 8'h44});
      cyc(1, 0, AW'(6), 32'hFFFFFFFF, 0, 1, 4'b0000);
      rd(AW'(6));
      chk("R3 empty lane set", {dq_drive, dq}, {1'b1, pat(6)});

      // R12 deselected write has no effect
      cyc(0, 0, AW'(7), 32'h0BADF00D, 1, 0, '0);
      cyc(1, 1, AW'(7), 32'h0BADF00D, 1, 0, '0);
      rd(AW'(7));
      chk("R12 unselected ignored", {dq_drive, dq}, {1'b1, pat(7)});

      // R10 write then read same address
      cyc(1, 0, AW'(9), 32'hCAFE0009, 1, 0, '0);
      chk("R11 write cycle off", {1'b0, dq_drive}, '0);
      rd(AW'(9));
      chk("R10 read after write", {dq_drive, dq}, {1'b1, 32'hCAFE0009});

      // R5/R6 pipelined read then deselect
      pipe_mode = 1'b1;
      idle(); idle();
      rd(AW'(3));
      chk("R5 not yet driven", {1'b0, dq_drive}, '0);
      idle();
      chk("R6 held through deselect", {dq_drive, dq}, {1'b1, pat(3)});
      idle();
      chk("R6 off after second edge", {dq_drive, dq}, '0);
      pipe_mode = 1'b0;
      rd(AW'(3)); idle();
      chk("R4 flow-through off after deselect", {dq_drive, dq}, '0);

      // R7 asynchronous output enable
      rd(AW'(4));
      out_en = 1'b0; #1;
      chk("R7 oe off async", {dq_drive, dq}, '0);
      out_en = 1'b1; #1;
      chk("R7 oe restored", {dq_drive, dq}, {1'b1, pat(4)});

      // R8/R9 sleep
      doze = 1'b1; #1;
      chk("R8 doze off async", {dq_drive, dq}, '0);
      cyc(1, 0, AW'(4), 32'h0, 1, 0, '0);
      rd(AW'(4));
      chk("R8 no read while asleep", {dq_drive, dq}, '0);
      doze = 1'b0;
      rd(AW'(4));
      chk("R9 contents kept, resume", {dq_drive, dq}, {1'b1, pat(4)});

      // random phase
      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
         int k;
         if (i % 500 == 0) pipe_mode = ~pipe_mode;
         out_en = ($urandom % 10) != 0;
         doze   = ($urandom % 16) == 0;
         k = $urandom % 10;
         if (k < 5)      rd(AW'($urandom % 8));
         else if (k < 7) cyc(1, 0, AW'($urandom % 8), $urandom, 1'($urandom % 2), 1,
                             NL'($urandom));
         else if (k < 9) idle();
         else            cyc(1'($urandom), 1'($urandom), AW'($urandom % 8), $urandom,
                             1'($urandom), 1'($urandom), NL'($urandom));
      end
      out_en = 1'b1; doze = 1'b0;
      idle(); idle();

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule